// File: doc/BRIEF.md
# Trace filter and timestamp selector

This block decides, every cycle, whether instruction trace may be emitted at the current privilege level and whether context-identifier and virtual-machine-identifier trace may be emitted. It also picks the timestamp value handed to the trace encoder. It holds two small control registers. The hypervisor-level register carries the level-2 enable, the level-0 enable, the context enable and a 2-bit timestamp select. The guest-level register carries only a 2-bit timestamp select, which the hypervisor register can defer to.

Software writes either register through a shared write-data bus, using one write strobe per register. Both registers can be read back combinationally. A synchronous warm reset clears every writable field. The timestamp is either the raw physical counter or the physical counter minus a virtualization offset. It is registered, so it appears one clock after its inputs.

Top module: `trc_filter_ts`

## Requirements
- R1: The hypervisor register keeps the level-0 enable at bit 0, the level-2 enable at bit 1, the context enable at bit 3 and the timestamp select at bits [6:5]. All other bits read as zero whatever was written, so writing all ones reads back 0x6B.
- R2: The guest register keeps only a timestamp select at bits [6:5], and every other bit reads as zero, so writing all ones reads back 0x60.
- R3: A synchronous warm reset (rst_n low at a clock edge) clears both registers to zero.
- R4: With self-hosted trace enabled and privilege level 2, trace_ok equals the level-2 enable bit.
- R5: With self-hosted trace enabled and privilege level 0, trace_ok equals the level-0 enable bit when tge and el2_en are both 1. In every other combination the level-0 enable is ignored and trace_ok is 1.
- R6: With self-hosted trace enabled, privilege levels 1 and 3 are not filtered by this block, and trace_ok is 1.
- R7: With self-hosted trace enabled, ctx_ok equals the context enable bit.
- R8: With self-hosted trace disabled, trace_ok and ctx_ok are 0 and the timestamp is the physical counter, whatever the register contents.
- R9: Timestamp select 01 yields phys_cnt minus virt_off, taken modulo 2^CNT_W. Selects 11 and 10 yield phys_cnt. The value on ts_out is the one computed from the inputs present at the previous clock edge.
- R10: A hypervisor timestamp select of 00 defers to the guest select, which is decoded as in R9. If the guest select is also 00, phys_cnt is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous warm reset, active low |
| hyp_wr_en | input | 1 | Write strobe for the hypervisor register |
| gst_wr_en | input | 1 | Write strobe for the guest register |
| wr_data | input | REG_W | Write data shared by both registers |
| hyp_rd_data | output | REG_W | Read-back of the hypervisor register |
| gst_rd_data | output | REG_W | Read-back of the guest register |
| priv | input | 2 | Current privilege level, 0 to 3 |
| tge | input | 1 | Trap-general-exceptions flag |
| el2_en | input | 1 | Level 2 enabled in the current security state |
| sh_en | input | 1 | Self-hosted trace enabled |
| phys_cnt | input | CNT_W | Physical counter value |
| virt_off | input | CNT_W | Virtual counter offset |
| trace_ok | output | 1 | Instruction trace allowed at the current level |
| ctx_ok | output | 1 | Context and VMID trace allowed |
| ts_out | output | CNT_W | Registered timestamp |

## Verification
The assertions assume that the privilege, mode and enable inputs hold a defined value at every clock edge after reset. They also assume that phys_cnt and virt_off are stable around the sampling edge, because the timestamp check compares ts_out with the previous cycle's counter. The bench drives every input on the falling edge, changes the registers only through the write strobes, and keeps the inputs steady through each rising edge, so these conditions always hold. Wraparound of the virtual subtraction is covered with an offset larger than the counter.

// File: rtl/trc_filter_pkg.sv
package trc_filter_pkg;
   localparam int BIT_E0    = 0;
   localparam int BIT_E2    = 1;
   localparam int BIT_CX    = 3;
   localparam int TS_LSB    = 5;
   localparam int TS_MSB    = 6;
   localparam int MIN_REG_W = TS_MSB + 1;

   typedef enum logic [1:0] {
      TS_DEFER = 2'b00,
      TS_VIRT  = 2'b01,
      TS_RSVD  = 2'b10,
      TS_PHYS  = 2'b11
   } ts_sel_e;

   typedef enum logic [1:0] {
      PL0 = 2'd0,
      PL1 = 2'd1,
      PL2 = 2'd2,
      PL3 = 2'd3
   } priv_e;

   typedef struct packed {
      ts_sel_e ts;
      logic    cx;
      logic    e2;
      logic    e0;
   } hyp_ctl_t;
endpackage

// File: rtl/trc_ctl_regs.sv
module trc_ctl_regs
   import trc_filter_pkg::*;
#(
   parameter int REG_W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hyp_we,
   input  logic             gst_we,
   input  logic [REG_W-1:0] wr_data,
   output hyp_ctl_t         hyp_q,
   output ts_sel_e          gst_ts,
   output logic [REG_W-1:0] hyp_rd,
   output logic [REG_W-1:0] gst_rd
);
   initial begin
      if (REG_W < MIN_REG_W) $error("REG_W too small for field layout");
   end

   hyp_ctl_t hyp_r;
   ts_sel_e  gst_r;
   logic     unused_wr;

   assign unused_wr = ^wr_data;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hyp_r <= '{ts: TS_DEFER, cx: 1'b0, e2: 1'b0, e0: 1'b0};
         gst_r <= TS_DEFER;
      end else begin
         if (hyp_we) begin
            hyp_r.ts <= ts_sel_e'(wr_data[TS_MSB:TS_LSB]);
            hyp_r.cx <= wr_data[BIT_CX];
            hyp_r.e2 <= wr_data[BIT_E2];
            hyp_r.e0 <= wr_data[BIT_E0];
         end
         if (gst_we) begin
            gst_r <= ts_sel_e'(wr_data[TS_MSB:TS_LSB]);
         end
      end
   end

   always_comb begin
      hyp_rd                  = '0;
      hyp_rd[BIT_E0]          = hyp_r.e0;
      hyp_rd[BIT_E2]          = hyp_r.e2;
      hyp_rd[BIT_CX]          = hyp_r.cx;
      hyp_rd[TS_MSB:TS_LSB]   = hyp_r.ts;
      gst_rd                  = '0;
      gst_rd[TS_MSB:TS_LSB]   = gst_r;
   end

   assign hyp_q  = hyp_r;
   assign gst_ts = gst_r;

   assert_warm_clear_R3: assert property (@(posedge clk)
      !rst_n |=> (hyp_rd == '0 && gst_rd == '0));
endmodule

// File: rtl/trc_permit.sv
module trc_permit
   import trc_filter_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     sh_en,
   input  priv_e    priv,
   input  logic     tge,
   input  logic     el2_en,
   input  hyp_ctl_t ctl,
   output logic     trace_ok,
   output logic     ctx_ok
);
   logic e0_applies;

   assign e0_applies = tge && el2_en;

   always_comb begin
      trace_ok = 1'b0;
      if (sh_en) begin
         unique case (priv)
            PL0:     trace_ok = e0_applies ? ctl.e0 : 1'b1;
            PL2:     trace_ok = ctl.e2;
            default: trace_ok = 1'b1;
         endcase
      end
   end

   assign ctx_ok = sh_en && ctl.cx;

   assert_el2_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (sh_en && priv == PL2) |-> (trace_ok == ctl.e2));
   assert_el0_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (sh_en && priv == PL0 && !(tge && el2_en)) |-> trace_ok);
   assert_other_levels_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (sh_en && (priv == PL1 || priv == PL3)) |-> trace_ok);
endmodule

// File: rtl/trc_ts_sel.sv
module trc_ts_sel
   import trc_filter_pkg::*;
#(
   parameter int CNT_W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sh_en,
   input  ts_sel_e          hyp_ts,
   input  ts_sel_e          gst_ts,
   input  logic [CNT_W-1:0] phys_cnt,
   input  logic [CNT_W-1:0] virt_off,
   output logic [CNT_W-1:0] ts_out
);
   initial begin
      if (CNT_W < 1) $error("CNT_W must be positive");
   end

   ts_sel_e          eff_sel;
   logic [CNT_W-1:0] virt_val;
   logic [CNT_W-1:0] ts_nxt;
   logic [CNT_W-1:0] ts_q;

   assign eff_sel  = (hyp_ts == TS_DEFER) ? gst_ts : hyp_ts;
   assign virt_val = phys_cnt - virt_off;
   assign ts_nxt   = (sh_en && eff_sel == TS_VIRT) ? virt_val : phys_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) ts_q <= '0;
      else        ts_q <= ts_nxt;
   end

   assign ts_out = ts_q;

   assert_shoff_phys_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(sh_en) && $past(rst_n)) |-> (ts_out == $past(phys_cnt)));
endmodule

// File: rtl/trc_filter_ts.sv
module trc_filter_ts
   import trc_filter_pkg::*;
#(
   parameter int REG_W = 64,
   parameter int CNT_W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hyp_wr_en,
   input  logic             gst_wr_en,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] hyp_rd_data,
   output logic [REG_W-1:0] gst_rd_data,
   input  logic [1:0]       priv,
   input  logic             tge,
   input  logic             el2_en,
   input  logic             sh_en,
   input  logic [CNT_W-1:0] phys_cnt,
   input  logic [CNT_W-1:0] virt_off,
   output logic             trace_ok,
   output logic             ctx_ok,
   output logic [CNT_W-1:0] ts_out
);
   hyp_ctl_t hyp_ctl;
   ts_sel_e  gst_ts;

   trc_ctl_regs #(.REG_W(REG_W)) regs_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .hyp_we (hyp_wr_en),
      .gst_we (gst_wr_en),
      .wr_data(wr_data),
      .hyp_q  (hyp_ctl),
      .gst_ts (gst_ts),
      .hyp_rd (hyp_rd_data),
      .gst_rd (gst_rd_data)
   );

   trc_permit permit_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .sh_en   (sh_en),
      .priv    (priv_e'(priv)),
      .tge     (tge),
      .el2_en  (el2_en),
      .ctl     (hyp_ctl),
      .trace_ok(trace_ok),
      .ctx_ok  (ctx_ok)
   );

   trc_ts_sel #(.CNT_W(CNT_W)) ts_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .sh_en   (sh_en),
      .hyp_ts  (hyp_ctl.ts),
      .gst_ts  (gst_ts),
      .phys_cnt(phys_cnt),
      .virt_off(virt_off),
      .ts_out  (ts_out)
   );

   assert_shoff_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !sh_en |-> (!trace_ok && !ctx_ok));
   assert_ctx_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      sh_en |-> (ctx_ok == hyp_rd_data[BIT_CX]));
endmodule

// File: tb/trc_filter_ts_tb_top.sv
module trc_filter_ts_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int REG_W = 64;
   localparam int CNT_W = 64;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             hyp_wr_en = 1'b0;
   logic             gst_wr_en = 1'b0;
   logic [REG_W-1:0] wr_data = '0;
   logic [REG_W-1:0] hyp_rd_data;
   logic [REG_W-1:0] gst_rd_data;
   logic [1:0]       priv = 2'd0;
   logic             tge = 1'b0;
   logic             el2_en = 1'b0;
   logic             sh_en = 1'b1;
   logic [CNT_W-1:0] phys_cnt = '0;
   logic [CNT_W-1:0] virt_off = '0;
   logic             trace_ok;
   logic             ctx_ok;
   logic [CNT_W-1:0] ts_out;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   trc_filter_ts #(.REG_W(REG_W), .CNT_W(CNT_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .hyp_wr_en(hyp_wr_en), .gst_wr_en(gst_wr_en),
      .wr_data(wr_data), .hyp_rd_data(hyp_rd_data), .gst_rd_data(gst_rd_data),
      .priv(priv), .tge(tge), .el2_en(el2_en), .sh_en(sh_en),
      .phys_cnt(phys_cnt), .virt_off(virt_off),
      .trace_ok(trace_ok), .ctx_ok(ctx_ok), .ts_out(ts_out)
   );

   task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
      end
   endtask

   task automatic wr_hyp(input logic [63:0] d);
      @(negedge clk);
      wr_data = d; hyp_wr_en = 1'b1;
      @(negedge clk);
      hyp_wr_en = 1'b0;
   endtask

   task automatic wr_gst(input logic [63:0] d);
      @(negedge clk);
      wr_data = d; gst_wr_en = 1'b1;
      @(negedge clk);
      gst_wr_en = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_reset();
      do_reset();
      chk("R3 hyp after reset", hyp_rd_data, 64'h0);
      chk("R3 gst after reset", gst_rd_data, 64'h0);
      sh_en = 1'b1; priv = 2'd2;
      #1 chk("R3/R4 level2 blocked after reset", {63'h0, trace_ok}, 64'h1 ^ 64'h1);
   endtask

   task automatic t_layout();
      wr_hyp('1);
      chk("R1 hyp all ones", hyp_rd_data, 64'h6B);
      wr_gst('1);
      chk("R2 gst all ones", gst_rd_data, 64'h60);
      wr_hyp(64'hFFFF_FFFF_FFFF_FF94);
      chk("R1 reserved bits dropped", hyp_rd_data, 64'h0);
   endtask

   task automatic t_el2();
      sh_en = 1'b1; priv = 2'd2;
      wr_hyp(64'h2);
      #1 chk("R4 level2 enabled", {63'h0, trace_ok}, 64'h1);
      wr_hyp(64'h1);
      #1 chk("R4 level2 prohibited", {63'h0, trace_ok}, 64'h0);
   endtask

   task automatic t_el0();
      sh_en = 1'b1; priv = 2'd0;
      wr_hyp(64'h0);
      tge = 1'b1; el2_en = 1'b1;
      #1 chk("R5 level0 prohibited", {63'h0, trace_ok}, 64'h0);
      tge = 1'b0;
      #1 chk("R5 ignored when tge=0", {63'h0, trace_ok}, 64'h1);
      tge = 1'b1; el2_en = 1'b0;
      #1 chk("R5 ignored when el2 off", {63'h0, trace_ok}, 64'h1);
      el2_en = 1'b1;
      wr_hyp(64'h1);
      #1 chk("R5 level0 allowed", {63'h0, trace_ok}, 64'h1);
   endtask

   task automatic t_other();
      sh_en = 1'b1;
      wr_hyp(64'h0);
      priv = 2'd1;
      #1 chk("R6 level1 unfiltered", {63'h0, trace_ok}, 64'h1);
      priv = 2'd3;
      #1 chk("R6 level3 unfiltered", {63'h0, trace_ok}, 64'h1);
   endtask

   task automatic t_ctx();
      sh_en = 1'b1;
      wr_hyp(64'h8);
      #1 chk("R7 ctx allowed", {63'h0, ctx_ok}, 64'h1);
      wr_hyp(64'h0);
      #1 chk("R7 ctx prohibited", {63'h0, ctx_ok}, 64'h0);
   endtask

   task automatic t_ts();
      sh_en = 1'b1;
      wr_hyp(64'h20);
      phys_cnt = 64'd1000; virt_off = 64'd300;
      @(negedge clk);
      chk("R9 virtual", ts_out, 64'd700);
      phys_cnt = 64'd5; virt_off = 64'd10;
      #1 chk("R9 latency holds old", ts_out, 64'd700);
      @(negedge clk);
      chk("R9 virtual wrap", ts_out, 64'hFFFF_FFFF_FFFF_FFFB);
      wr_hyp(64'h60);
      phys_cnt = 64'd1234;
      @(negedge clk);
      chk("R9 physical 11", ts_out, 64'd1234);
      wr_hyp(64'h40);
      phys_cnt = 64'd999;
      @(negedge clk);
      chk("R9 reserved 10 physical", ts_out, 64'd999);
   endtask

   task automatic t_defer();
      sh_en = 1'b1;
      wr_hyp(64'h0);
      wr_gst(64'h20);
      phys_cnt = 64'd500; virt_off = 64'd20;
      @(negedge clk);
      chk("R10 defer to guest virtual", ts_out, 64'd480);
      wr_gst(64'h60);
      @(negedge clk);
      chk("R10 defer to guest physical", ts_out, 64'd500);
      wr_gst(64'h0);
      @(negedge clk);
      chk("R10 both defer physical", ts_out, 64'd500);
   endtask

   task automatic t_shoff();
      wr_hyp('1);
      wr_hyp(64'h2B);
      sh_en = 1'b0; priv = 2'd2; tge = 1'b1; el2_en = 1'b1;
      phys_cnt = 64'd800; virt_off = 64'd100;
      @(negedge clk);
      chk("R8 trace blocked", {63'h0, trace_ok}, 64'h0);
      chk("R8 ctx blocked", {63'h0, ctx_ok}, 64'h0);
      chk("R8 timestamp physical", ts_out, 64'd800);
      sh_en = 1'b1;
   endtask

   task automatic t_warm();
      wr_hyp('1);
      wr_gst('1);
      do_reset();
      chk("R3 warm reset hyp", hyp_rd_data, 64'h0);
      chk("R3 warm reset gst", gst_rd_data, 64'h0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      t_reset();
      t_layout();
      t_el2();
      t_el0();
      t_other();
      t_ctx();
      t_ts();
      t_defer();
      t_shoff();
      t_warm();
      finish_run();
   end
endmodule